// File: doc/BRIEF.md
# Four-Voice Wavetable Phase Oscillator

The block runs four wavetable voices. Each voice keeps a 24-bit phase accumulator and a 24-bit phase increment, both in 9.15 fixed point, which a host sets through a byte-wide register port. On each sample tick, while the mode input selects wavetable operation, every voice adds its increment to its phase. The block then looks up one byte per voice in two external 1024-byte sample RAMs and presents all four results as signed samples, marked by a one-cycle valid strobe.

The top 9 integer bits of a phase select an entry in a 512-byte table. Even-numbered voices use the lower half of their RAM and odd-numbered voices use the upper half. Voices 0 and 1 share RAM A, and voices 2 and 3 share RAM B. Each RAM is read through one synchronous port, so the two voices of a bank are fetched one after the other. Mixing and volume are left to the logic downstream.

Top module: `wt_voice_osc`

## Requirements
- R1: After reset every phase and increment reads as zero, `voice_o` is zero and `voice_valid_o` is low.
- R2: Register map relative to the window base (default 0x10): voice v owns an 8-byte slot at offset 8v. The phase sits at bytes 0..3 of the slot and the increment at bytes 4..7. Each value is big-endian, with the first byte of its four the most significant. That first byte always reads 0 and ignores writes. Any address outside the 32-byte window reads 0.
- R3: A tick accepted while `mode_i` equals 2 (wavetable) replaces each phase with phase + increment, modulo 2^24.
- R4: A tick has no effect while `mode_i` is not 2, and also while a fetch started by an earlier tick is still running (within three cycles of its acceptance). No phase changes and no strobe follows.
- R5: The RAM address of a voice is {v[0], phase[23:15]}, taken from the phase as updated by the tick. Voices 0 and 1 use RAM A and voices 2 and 3 use RAM B. In the first cycle after the tick, the read enables are high and the addresses belong to voices 0 and 2. In the second cycle they belong to voices 1 and 3. The RAMs return data one cycle after each read.
- R6: The output sample of each voice is its fetched byte with the most significant bit inverted, placed at `voice_o[8v+7:8v]`.
- R7: `voice_valid_o` goes high for exactly one cycle, three clock edges after the edge that accepts the tick. All four lanes change at that edge and hold at all other times.
- R8: If a register write and an accepted tick fall in the same cycle, the written byte is merged into the register first, and the increment is added to the merged value.
- R9: A phase that passes 0xFFFFFF wraps: 0xFFFF00 + 0x000200 gives 0x000100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Operating mode; 2 enables wavetable operation |
| tick_i | input | 1 | Sample tick request |
| reg_we_i | input | 1 | Register byte write enable |
| reg_addr_i | input | AW (8) | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ram_a_rd_o | output | 1 | Read enable for sample RAM A |
| ram_a_addr_o | output | IDX_W+1 (10) | Byte address into RAM A |
| ram_a_data_i | input | DW (8) | Data returned by RAM A, one cycle after a read |
| ram_b_rd_o | output | 1 | Read enable for sample RAM B |
| ram_b_addr_o | output | IDX_W+1 (10) | Byte address into RAM B |
| ram_b_data_i | input | DW (8) | Data returned by RAM B, one cycle after a read |
| voice_o | output | 4*DW (32) | Four signed voice samples, lane v at bits 8v+7:8v |
| voice_valid_o | output | 1 | One-cycle strobe marking fresh samples |

## Verification
The assertions check the fetch timing on every cycle. They check that a fetch begins only after a tick seen in wavetable mode, that the even-voice addresses come before the odd-voice ones, that the strobe lasts one cycle and comes two cycles after the last read, and that the most significant byte of each register reads zero. The arithmetic can only be shown by the directed scenarios: the accumulated phase values, wraparound, merging a write with a tick in the same cycle, the byte ordering of the register map and the sample values with the inverted MSB. The bench checks each of these against its own model of the phases and of the RAM contents.

// File: rtl/wt_voice_osc.sv
`timescale 1ns/1ps
module wt_voice_osc #(
  parameter int PH_W = 24,
  parameter int IDX_W = 9,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] REG_BASE = 8'h10,
  parameter logic [1:0] WT_MODE = 2'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              ram_a_rd_o,
  output logic [IDX_W:0]    ram_a_addr_o,
  input  logic [DW-1:0]     ram_a_data_i,
  output logic              ram_b_rd_o,
  output logic [IDX_W:0]    ram_b_addr_o,
  input  logic [DW-1:0]     ram_b_data_i,
  output logic [4*DW-1:0]   voice_o,
  output logic              voice_valid_o
);
  localparam int NV = 4;
  localparam int SLOT_B = 4;
  localparam int SPAN = NV * 2 * SLOT_B;
  localparam int REG_BITS = 8 * SLOT_B;
  localparam logic [DW-1:0] SIGN_FLIP = DW'(1) << (DW - 1);

  logic [PH_W-1:0] phase [NV];
  logic [PH_W-1:0] incr  [NV];
  logic [PH_W-1:0] ph_nx [NV];
  logic [PH_W-1:0] in_nx [NV];

  logic [AW-1:0] off;
  logic          hit;
  logic [1:0]    sel_v;
  logic          sel_inc;
  logic [1:0]    sel_b;

  assign off     = reg_addr_i - REG_BASE;
  assign hit     = (int'(reg_addr_i) >= int'(REG_BASE)) && (int'(reg_addr_i) < int'(REG_BASE) + SPAN);
  assign sel_v   = off[4:3];
  assign sel_inc = off[2];
  assign sel_b   = off[1:0];

  always_comb begin
    for (int v = 0; v < NV; v++) begin
      ph_nx[v] = phase[v];
      in_nx[v] = incr[v];
      if (reg_we_i && hit && int'(sel_v) == v) begin
        for (int b = 0; b < PH_W; b++) begin
          if (SLOT_B - 1 - b / 8 == int'(sel_b)) begin
            if (sel_inc) in_nx[v][b] = reg_wdata_i[b % 8];
            else         ph_nx[v][b] = reg_wdata_i[b % 8];
          end
        end
      end
    end
  end

  logic [REG_BITS-1:0] rd_word;
  assign rd_word     = sel_inc ? REG_BITS'(incr[sel_v]) : REG_BITS'(phase[sel_v]);
  assign reg_rdata_o = hit ? rd_word[{2'(SLOT_B - 1) - sel_b, 3'b000} +: 8] : 8'h00;

  logic          busy;
  logic [1:0]    step;
  logic          accept;
  logic [DW-1:0] hold_a, hold_b;

  assign accept       = tick_i && (mode_i == WT_MODE) && !busy;
  assign ram_a_rd_o   = busy && (step != 2'd2);
  assign ram_b_rd_o   = ram_a_rd_o;
  assign ram_a_addr_o = {step[0], phase[{1'b0, step[0]}][PH_W-1 -: IDX_W]};
  assign ram_b_addr_o = {step[0], phase[{1'b1, step[0]}][PH_W-1 -: IDX_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NV; v++) begin
        phase[v] <= '0;
        incr[v]  <= '0;
      end
      busy          <= 1'b0;
      step          <= 2'd0;
      hold_a        <= '0;
      hold_b        <= '0;
      voice_o       <= '0;
      voice_valid_o <= 1'b0;
    end else begin
      for (int v = 0; v < NV; v++) begin
        incr[v]  <= in_nx[v];
        phase[v] <= accept ? ph_nx[v] + in_nx[v] : ph_nx[v];
      end
      voice_valid_o <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        step <= 2'd0;
      end else if (busy) begin
        step <= step + 2'd1;
        if (step == 2'd1) begin
          hold_a <= ram_a_data_i;
          hold_b <= ram_b_data_i;
        end
        if (step == 2'd2) begin
          busy                <= 1'b0;
          voice_valid_o       <= 1'b1;
          voice_o[0*DW +: DW] <= hold_a ^ SIGN_FLIP;
          voice_o[1*DW +: DW] <= ram_a_data_i ^ SIGN_FLIP;
          voice_o[2*DW +: DW] <= hold_b ^ SIGN_FLIP;
          voice_o[3*DW +: DW] <= ram_b_data_i ^ SIGN_FLIP;
        end
      end
    end
  end
endmodule

// File: rtl/wt_voice_osc_chk.sv
`timescale 1ns/1ps
module wt_voice_osc_chk #(
  parameter int IDX_W = 9,
  parameter int AW = 8,
  parameter logic [AW-1:0] REG_BASE = 8'h10,
  parameter logic [1:0] WT_MODE = 2'd2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode_i,
  input logic            tick_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic [7:0]      reg_rdata_o,
  input logic            ram_a_rd_o,
  input logic [IDX_W:0]  ram_a_addr_o,
  input logic [IDX_W:0]  ram_b_addr_o,
  input logic            voice_valid_o
);
  logic          in_win;
  logic [AW-1:0] rel;
  assign rel    = reg_addr_i - REG_BASE;
  assign in_win = (int'(reg_addr_i) >= int'(REG_BASE)) && (int'(reg_addr_i) < int'(REG_BASE) + 32);

  assert_top_byte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && rel[1:0] == 2'b00) |-> reg_rdata_o == 8'h00);

  assert_fetch_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_a_rd_o) |-> ($past(tick_i) && $past(mode_i) == WT_MODE));

  assert_even_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_a_rd_o) |-> (!ram_a_addr_o[IDX_W] && !ram_b_addr_o[IDX_W]));

  assert_odd_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_a_rd_o && $past(ram_a_rd_o)) |-> (ram_a_addr_o[IDX_W] && ram_b_addr_o[IDX_W]));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    voice_valid_o |=> !voice_valid_o);

  assert_valid_after_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    voice_valid_o |-> (!$past(ram_a_rd_o) && $past(ram_a_rd_o, 2) && $past(ram_a_rd_o, 3)));
endmodule

bind wt_voice_osc wt_voice_osc_chk #(
  .IDX_W(IDX_W), .AW(AW), .REG_BASE(REG_BASE), .WT_MODE(WT_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tick_i(tick_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .ram_a_rd_o(ram_a_rd_o), .ram_a_addr_o(ram_a_addr_o), .ram_b_addr_o(ram_b_addr_o),
  .voice_valid_o(voice_valid_o)
);

// File: tb/sim_wt_voice_osc.sv
`timescale 1ns/1ps
module sim_wt_voice_osc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        tick_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'h00;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic [7:0]  reg_rdata_o;
  logic        ram_a_rd_o, ram_b_rd_o;
  logic [9:0]  ram_a_addr_o, ram_b_addr_o;
  logic [7:0]  ram_a_data_i = 8'h00, ram_b_data_i = 8'h00;
  logic [31:0] voice_o;
  logic        voice_valid_o;

  int checks = 0;
  int fails = 0;
  logic [23:0] m_ph [4];
  logic [23:0] m_in [4];

  always #2.5 clk = ~clk;

  wt_voice_osc u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tick_i(tick_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .ram_a_rd_o(ram_a_rd_o), .ram_a_addr_o(ram_a_addr_o), .ram_a_data_i(ram_a_data_i),
    .ram_b_rd_o(ram_b_rd_o), .ram_b_addr_o(ram_b_addr_o), .ram_b_data_i(ram_b_data_i),
    .voice_o(voice_o), .voice_valid_o(voice_valid_o)
  );

  function automatic logic [7:0] byte_a(input logic [9:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd7 + 16'd3;
    return t[7:0];
  endfunction

  function automatic logic [7:0] byte_b(input logic [9:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd13;
    return t[7:0] ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) begin
    if (ram_a_rd_o) ram_a_data_i <= byte_a(ram_a_addr_o);
    if (ram_b_rd_o) ram_b_data_i <= byte_b(ram_b_addr_o);
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic set_val(input int v, input bit is_inc, input logic [23:0] val);
    logic [7:0] base;
    base = 8'h10 + 8'(v * 8) + (is_inc ? 8'd4 : 8'd0);
    write_reg(base + 8'd1, val[23:16]);
    write_reg(base + 8'd2, val[15:8]);
    write_reg(base + 8'd3, val[7:0]);
    if (is_inc) m_in[v] = val; else m_ph[v] = val;
  endtask

  task automatic get_val(input int v, input bit is_inc, output logic [23:0] val);
    logic [7:0] base, d;
    base = 8'h10 + 8'(v * 8) + (is_inc ? 8'd4 : 8'd0);
    read_reg(base + 8'd1, d); val[23:16] = d;
    read_reg(base + 8'd2, d); val[15:8] = d;
    read_reg(base + 8'd3, d); val[7:0] = d;
  endtask

  function automatic logic [7:0] exp_lane(input int v);
    logic [9:0] a;
    a = {1'(v % 2), m_ph[v][23:15]};
    return ((v < 2) ? byte_a(a) : byte_b(a)) ^ 8'h80;
  endfunction

  task automatic wait_and_check_lanes(input string req);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(voice_valid_o == 1'b1, "R7 strobe", 32'(voice_valid_o), 32'd1);
    for (int v = 0; v < 4; v++)
      check(voice_o[v*8 +: 8] == exp_lane(v), req, 32'(voice_o[v*8 +: 8]), 32'(exp_lane(v)));
    @(negedge clk);
    check(voice_valid_o == 1'b0, "R7 one cycle", 32'(voice_valid_o), 32'd0);
  endtask

  task automatic tick_once(input string req);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    for (int v = 0; v < 4; v++) m_ph[v] = m_ph[v] + m_in[v];
    wait_and_check_lanes(req);
  endtask

  task automatic t_reset();
    logic [23:0] r;
    check(voice_valid_o == 1'b0, "R1 valid", 32'(voice_valid_o), 32'd0);
    check(voice_o == 32'd0, "R1 voices", voice_o, 32'd0);
    for (int v = 0; v < 4; v++) begin
      get_val(v, 1'b0, r); check(r == 24'd0, "R1 phase", 32'(r), 32'd0);
      get_val(v, 1'b1, r); check(r == 24'd0, "R1 incr", 32'(r), 32'd0);
    end
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    logic [23:0] r;
    write_reg(8'h1A, 8'hC3);
    m_ph[1] = 24'h00C300;
    get_val(1, 1'b0, r); check(r == 24'h00C300, "R2 big-endian middle byte", 32'(r), 32'h00C300);
    write_reg(8'h2C, 8'hFF);
    read_reg(8'h2C, d); check(d == 8'h00, "R2 top byte ignores write", 32'(d), 32'd0);
    set_val(2, 1'b1, 24'hA1B2C3);
    read_reg(8'h25, d); check(d == 8'hA1, "R2 incr byte1", 32'(d), 32'hA1);
    read_reg(8'h27, d); check(d == 8'hC3, "R2 incr byte3", 32'(d), 32'hC3);
    read_reg(8'h30, d); check(d == 8'h00, "R2 above window", 32'(d), 32'd0);
    read_reg(8'h0F, d); check(d == 8'h00, "R2 below window", 32'(d), 32'd0);
    set_val(1, 1'b0, 24'd0);
    set_val(2, 1'b1, 24'd0);
  endtask

  task automatic t_basic();
    logic [23:0] r;
    mode_i = 2'd2;
    set_val(0, 1'b1, 24'h012345);
    set_val(1, 1'b1, 24'h100000);
    set_val(2, 1'b1, 24'h0F0F0F);
    set_val(3, 1'b1, 24'h3FFFFF);
    set_val(3, 1'b0, 24'h400000);
    tick_once("R6 lane after tick 1");
    tick_once("R6 lane after tick 2");
    tick_once("R5 lane after tick 3");
    for (int v = 0; v < 4; v++) begin
      get_val(v, 1'b0, r);
      check(r == m_ph[v], "R3 accumulated phase", 32'(r), 32'(m_ph[v]));
    end
  endtask

  task automatic t_order();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    for (int v = 0; v < 4; v++) m_ph[v] = m_ph[v] + m_in[v];
    check(ram_a_rd_o && ram_a_addr_o == {1'b0, m_ph[0][23:15]}, "R5 first A addr",
          32'(ram_a_addr_o), 32'({1'b0, m_ph[0][23:15]}));
    check(ram_b_rd_o && ram_b_addr_o == {1'b0, m_ph[2][23:15]}, "R5 first B addr",
          32'(ram_b_addr_o), 32'({1'b0, m_ph[2][23:15]}));
    @(negedge clk);
    check(ram_a_rd_o && ram_a_addr_o == {1'b1, m_ph[1][23:15]}, "R5 second A addr",
          32'(ram_a_addr_o), 32'({1'b1, m_ph[1][23:15]}));
    check(ram_b_rd_o && ram_b_addr_o == {1'b1, m_ph[3][23:15]}, "R5 second B addr",
          32'(ram_b_addr_o), 32'({1'b1, m_ph[3][23:15]}));
    @(negedge clk);
    @(negedge clk);
    check(voice_valid_o == 1'b1, "R7 strobe after ordered reads", 32'(voice_valid_o), 32'd1);
  endtask

  task automatic t_wrap();
    logic [23:0] r;
    set_val(0, 1'b0, 24'hFFFF00);
    set_val(0, 1'b1, 24'h000200);
    tick_once("R9 lane after wrap");
    get_val(0, 1'b0, r);
    check(r == 24'h000100, "R9 wrapped phase", 32'(r), 32'h000100);
  endtask

  task automatic t_ignore();
    logic [23:0] r;
    logic seen;
    mode_i = 2'd1;
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (voice_valid_o) seen = 1'b1;
    end
    check(!seen, "R4 no strobe outside mode 2", 32'(seen), 32'd0);
    get_val(0, 1'b0, r);
    check(r == m_ph[0], "R4 phase held outside mode 2", 32'(r), 32'(m_ph[0]));
    mode_i = 2'd2;
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk);
    @(negedge clk); tick_i = 1'b0;
    for (int v = 0; v < 4; v++) m_ph[v] = m_ph[v] + m_in[v];
    @(negedge clk);
    @(negedge clk);
    check(voice_valid_o == 1'b1, "R7 strobe for accepted tick", 32'(voice_valid_o), 32'd1);
    get_val(1, 1'b0, r);
    check(r == m_ph[1], "R4 busy tick ignored", 32'(r), 32'(m_ph[1]));
    @(negedge clk);
  endtask

  task automatic t_write_tick();
    logic [23:0] r;
    set_val(2, 1'b0, 24'h000000);
    set_val(2, 1'b1, 24'h000010);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 8'h23; reg_wdata_i = 8'h40;
    tick_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; tick_i = 1'b0;
    m_ph[2] = 24'h000040;
    for (int v = 0; v < 4; v++) m_ph[v] = m_ph[v] + m_in[v];
    wait_and_check_lanes("R8 lane after merged write");
    get_val(2, 1'b0, r);
    check(r == 24'h000050, "R8 write merged before add", 32'(r), 32'h000050);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int v = 0; v < 4; v++) begin m_ph[v] = '0; m_in[v] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_order();
    t_wrap();
    t_ignore();
    t_write_tick();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule